// File: doc/BRIEF.md
# Chained Buffer Address Slice Selector

This block sits beside the storage array of one frame buffer device that is built to be chained with identical neighbours. Every device in the chain sees the same write data, the same pointer controls and the same jump address, and all read outputs join on one shared bus. Each device keeps a copy of the global write and read pointers. It compares the upper field of each pointer with its own slot number, and so only the owner of the current address writes its array or drives the bus. The chain behaves as one seamless memory.

Two configuration inputs set the behaviour: the device's slot number and the index of the highest slot in the chain. Together with the slice width they fix where the global pointers wrap, so every device wraps in the same cycle without exchanging signals. An illegal setting keeps the device silent: it writes nothing and never drives the bus.

Top module: `cascade_slice_sel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both global pointers read 0, `q_oe` is 0 and `mem_we` is 0.
- R2: `mem_we` is 1 in the same cycle in which `wr_en` is 1, the setting is legal and pointer bits [SLICE_W+3:SLICE_W] of `wr_ptr` equal `slot`. `mem_waddr` is always bits [SLICE_W-1:0] of `wr_ptr`, and `mem_wdata` equals `wdata`.
- R3: After a clock edge at which `rd_en` is 1 and the device owns `rd_ptr` (same field test as R2) with a legal setting, `q_oe` is 1 for the following cycle and `q` carries `mem_rdata`. After any other edge `q_oe` is 0.
- R4: An enable with no clear and no jump moves the pointer up by one, as long as the pointer is below the chain's last address.
- R5: The chain's last address is (`last_slot`+1)·2^SLICE_W − 1. An advance taken from that address gives 0.
- R6: A clear forces its pointer to 0 and takes priority over a jump and an advance in the same cycle.
- R7: A jump (without a clear) loads `jump_addr`, which takes priority over an advance. A jump address above the chain's last address loads 0.
- R8: A setting is illegal when `slot` > `last_slot` or `last_slot` > 7. An illegal setting holds `mem_we`, `mem_re` and `q_oe` at 0.
- R9: With `last_slot` = 0 the pointers wrap at 2^SLICE_W − 1, and slot 0 owns every address.
- R10: `mem_re` is 1 in the same cycle as `rd_en` exactly when the device owns `rd_ptr` with a legal setting. `mem_raddr` is bits [SLICE_W-1:0] of `rd_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot | input | 4 | Position of this device in the chain, 0 = lowest |
| last_slot | input | 4 | Index of the highest device, 0 = single device |
| wr_en | input | 1 | Write one word and advance the write pointer |
| wr_clr | input | 1 | Clear the write pointer to 0 |
| wr_jump | input | 1 | Load the write pointer from jump_addr |
| rd_en | input | 1 | Read one word and advance the read pointer |
| rd_clr | input | 1 | Clear the read pointer to 0 |
| rd_jump | input | 1 | Load the read pointer from jump_addr |
| jump_addr | input | GADDR_W | Global address for jumps |
| wdata | input | DATA_W | Write data shared by the chain |
| mem_rdata | input | DATA_W | Read data from the local array, one cycle after mem_re |
| mem_we | output | 1 | Local array write strobe |
| mem_waddr | output | SLICE_W | Local write address |
| mem_wdata | output | DATA_W | Local write data |
| mem_re | output | 1 | Local array read strobe |
| mem_raddr | output | SLICE_W | Local read address |
| wr_ptr | output | GADDR_W | Global write pointer |
| rd_ptr | output | GADDR_W | Global read pointer |
| q_oe | output | 1 | Bus drive enable |
| q | output | DATA_W | Shared bus output, high impedance when q_oe is 0 |

## Verification
`mem_we`, `mem_re` and the local addresses are combinational, so they are due in the same cycle as the stimulus. The bench drives on the falling edge and checks one time step later. The pointers and `q_oe` change at the next rising edge, and the bench checks them on the falling edge that follows, one cycle after the stimulus. Wrap and jump corners are reached by jumping close to the chain's last address, because walking a whole slice would take too many cycles.

// File: rtl/cascade_slice_sel.sv
module cascade_slice_sel #(
  parameter int GADDR_W = 24,
  parameter int SLICE_W = 20,
  parameter int DATA_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         slot,
  input  logic [3:0]         last_slot,
  input  logic               wr_en,
  input  logic               wr_clr,
  input  logic               wr_jump,
  input  logic               rd_en,
  input  logic               rd_clr,
  input  logic               rd_jump,
  input  logic [GADDR_W-1:0] jump_addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_we,
  output logic [SLICE_W-1:0] mem_waddr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_re,
  output logic [SLICE_W-1:0] mem_raddr,
  output logic [GADDR_W-1:0] wr_ptr,
  output logic [GADDR_W-1:0] rd_ptr,
  output logic               q_oe,
  output logic [DATA_W-1:0]  q
);

  localparam int EXT_W = GADDR_W + 1;

  logic [GADDR_W-1:0] top_addr;
  logic               cfg_ok;
  logic               own_w;
  logic               own_r;

  assign top_addr = GADDR_W'(((EXT_W'(last_slot) + EXT_W'(1)) << SLICE_W) - EXT_W'(1));
  assign cfg_ok   = (slot <= last_slot) && (last_slot <= 4'd7);
  assign own_w    = cfg_ok && (wr_ptr[SLICE_W +: 4] == slot);
  assign own_r    = cfg_ok && (rd_ptr[SLICE_W +: 4] == slot);

  function automatic logic [GADDR_W-1:0] step_ptr(
    input logic [GADDR_W-1:0] cur,
    input logic               clr,
    input logic               jmp,
    input logic               adv,
    input logic [GADDR_W-1:0] dest,
    input logic [GADDR_W-1:0] top
  );
    if (clr)      return '0;
    else if (jmp) return (dest > top) ? '0 : dest;
    else if (adv) return (cur >= top) ? '0 : cur + GADDR_W'(1);
    else          return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      q_oe   <= 1'b0;
    end else begin
      wr_ptr <= step_ptr(wr_ptr, wr_clr, wr_jump, wr_en, jump_addr, top_addr);
      rd_ptr <= step_ptr(rd_ptr, rd_clr, rd_jump, rd_en, jump_addr, top_addr);
      q_oe   <= rd_en && own_r;
    end
  end

  assign mem_we    = wr_en && own_w;
  assign mem_waddr = wr_ptr[SLICE_W-1:0];
  assign mem_wdata = wdata;
  assign mem_re    = rd_en && own_r;
  assign mem_raddr = rd_ptr[SLICE_W-1:0];
  assign q         = q_oe ? mem_rdata : 'z;

endmodule

module cascade_slice_sel_chk #(
  parameter int GADDR_W = 24,
  parameter int SLICE_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         slot,
  input logic [3:0]         last_slot,
  input logic               wr_en,
  input logic               wr_clr,
  input logic               wr_jump,
  input logic               rd_en,
  input logic               rd_clr,
  input logic               rd_jump,
  input logic               mem_we,
  input logic               mem_re,
  input logic               q_oe,
  input logic [GADDR_W-1:0] wr_ptr,
  input logic [GADDR_W-1:0] rd_ptr
);

  logic [GADDR_W:0] chk_top;
  assign chk_top = (GADDR_W+1)'((32'(last_slot) + 1) * (32'(1) << SLICE_W) - 1);

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_en && (slot <= last_slot)); // R2
  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    q_oe |-> $past(rd_en)); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_clr && !rd_jump && ({1'b0, rd_ptr} < chk_top)) |=> rd_ptr == $past(rd_ptr) + 1'b1); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_clr && !wr_jump && ({1'b0, wr_ptr} == chk_top)) |=> wr_ptr == '0); // R5
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> wr_ptr == '0); // R6
  AST_SILENT_BAD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (last_slot > 4'd7) |-> !mem_we && !mem_re); // R8

endmodule

bind cascade_slice_sel cascade_slice_sel_chk #(.GADDR_W(GADDR_W), .SLICE_W(SLICE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .slot(slot), .last_slot(last_slot),
  .wr_en(wr_en), .wr_clr(wr_clr), .wr_jump(wr_jump),
  .rd_en(rd_en), .rd_clr(rd_clr), .rd_jump(rd_jump),
  .mem_we(mem_we), .mem_re(mem_re), .q_oe(q_oe),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/test_cascade_slice_sel.sv
module test_cascade_slice_sel;
  localparam int GW = 24;
  localparam int SW = 20;
  localparam int DW = 12;
  localparam int SL = 1 << SW;

  logic clk = 0, rst_n = 0;
  logic [3:0] slot = 0, last_slot = 0;
  logic wr_en = 0, wr_clr = 0, wr_jump = 0, rd_en = 0, rd_clr = 0, rd_jump = 0;
  logic [GW-1:0] jump_addr = 0;
  logic [DW-1:0] wdata = 0, mem_rdata = 0;
  logic mem_we, mem_re, q_oe;
  logic [SW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, q;
  logic [GW-1:0] wr_ptr, rd_ptr;
  int n_chk = 0, n_bad = 0;

  cascade_slice_sel #(.GADDR_W(GW), .SLICE_W(SW), .DATA_W(DW)) i_cascade_slice_sel (
    .clk(clk), .rst_n(rst_n), .slot(slot), .last_slot(last_slot),
    .wr_en(wr_en), .wr_clr(wr_clr), .wr_jump(wr_jump),
    .rd_en(rd_en), .rd_clr(rd_clr), .rd_jump(rd_jump),
    .jump_addr(jump_addr), .wdata(wdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .q_oe(q_oe), .q(q));

  always #4 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic jump_both(input longint a);
    jump_addr = GW'(a); wr_jump = 1; rd_jump = 1;
    cyc();
    wr_jump = 0; rd_jump = 0;
  endtask

  task automatic t_reset();
    check("R1 wr_ptr", wr_ptr, 0);
    check("R1 rd_ptr", rd_ptr, 0);
    check("R1 q_oe", q_oe, 0);
    check("R1 mem_we", mem_we, 0);
  endtask

  task automatic t_write_own();
    slot = 2; last_slot = 3;
    jump_both(2*SL + 5);
    wr_en = 1; wdata = 12'h5A5; #1;
    check("R2 mem_we owned", mem_we, 1);
    check("R2 mem_waddr", mem_waddr, 5);
    check("R2 mem_wdata", mem_wdata, 12'h5A5);
    @(negedge clk);
    check("R4 wr_ptr step", wr_ptr, 2*SL + 6);
    wr_en = 0;
    jump_both(SL + 3);
    wr_en = 1; #1;
    check("R2 mem_we other slot", mem_we, 0);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_read();
    slot = 1; last_slot = 3;
    jump_both(SL + 7);
    rd_en = 1; mem_rdata = 12'hABC; #1;
    check("R10 mem_re owned", mem_re, 1);
    check("R10 mem_raddr", mem_raddr, 7);
    @(negedge clk);
    rd_en = 0;
    check("R3 q_oe owned", q_oe, 1);
    check("R3 q data", q, 12'hABC);
    check("R4 rd_ptr step", rd_ptr, SL + 8);
    cyc();
    check("R3 q_oe idle", q_oe, 0);
    jump_both(3*SL);
    rd_en = 1; #1;
    check("R10 mem_re other slot", mem_re, 0);
    @(negedge clk); rd_en = 0;
    check("R3 q_oe other slot", q_oe, 0);
  endtask

  task automatic t_wrap();
    slot = 0; last_slot = 3;
    jump_both(4*SL - 1);
    wr_en = 1; rd_en = 1;
    cyc();
    wr_en = 0; rd_en = 0;
    check("R5 wr wrap", wr_ptr, 0);
    check("R5 rd wrap", rd_ptr, 0);
    last_slot = 0;
    jump_both(SL - 1);
    wr_en = 1; #1;
    check("R9 single owns top", mem_we, 1);
    @(negedge clk); wr_en = 0;
    check("R9 single wrap", wr_ptr, 0);
  endtask

  task automatic t_priority();
    last_slot = 3;
    jump_both(100);
    wr_clr = 1; wr_jump = 1; wr_en = 1; jump_addr = 24'h2345;
    cyc();
    wr_clr = 0; wr_jump = 0; wr_en = 0;
    check("R6 clr wins", wr_ptr, 0);
    rd_jump = 1; rd_en = 1; jump_addr = 24'h12345;
    cyc();
    rd_jump = 0; rd_en = 0;
    check("R7 jump over advance", rd_ptr, 24'h12345);
    last_slot = 1;
    jump_both(3*SL);
    check("R7 jump beyond top", wr_ptr, 0);
  endtask

  task automatic t_invalid();
    last_slot = 9; slot = 2;
    jump_both(2*SL + 1);
    wr_en = 1; rd_en = 1; #1;
    check("R8 no we", mem_we, 0);
    check("R8 no re", mem_re, 0);
    @(negedge clk); wr_en = 0; rd_en = 0;
    check("R8 no oe", q_oe, 0);
    last_slot = 3; slot = 5;
    jump_both(0);
    wr_en = 1; rd_en = 1; #1;
    check("R8 slot above last no we", mem_we, 0);
    @(negedge clk); wr_en = 0; rd_en = 0;
    check("R8 slot above last no oe", q_oe, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_own();
        t_read();
        t_wrap();
        t_priority();
        t_invalid();
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule